// File: doc/BRIEF.md
# Sticky Error Status Capture Unit

This block logs asynchronous faults reported by the bus and cache ECC checkers of a memory subsystem. Each reported event names an error type, and the unit keeps one sticky status bit per type. Around those bits it keeps a flag for same-type repeats, a bit that records the privilege level present when the event was detected, and a trap request line that an interrupt-enable input gates. Software reads the status word and clears bits by writing ones to them. Reading never changes any state.

One shared fault address register, one 9-bit data syndrome and one 4-bit tag syndrome each hold the details of a single event. A field fills from the first event that reaches it while it is unlocked. It then locks to the status bit of that event and ignores later events, unless a later event belongs to a strictly more severe class. Severity runs uncorrectable, then software-correctable, then hardware-corrected. A field unlocks only when the status bit that owns it is cleared, even if other status bits stay set. After unlocking, the field keeps its old value until the next capture.

Events are tagged with a transaction id and a 16-byte subunit index, so several ECC hits from one 64-byte transfer can be recognised. Only the first hit in such a transfer is logged.

Top module: `err_status_capture`

## Requirements
- R1: A cycle with `clr_en` high clears every status bit whose `clr_data` bit is 1, visible after the next clock edge. Bits whose `clr_data` bit is 0 keep their value. A cycle with no accepted event and `clr_en` low leaves `status` unchanged.
- R2: An accepted event of type t (0 to 7) sets `status[t]`. The bit stays set until it is cleared as in R1.
- R3: `status[8]` is the repeat flag. It is set when an accepted event of class uncorrectable or software-correctable arrives while its own status bit is already set and that bit is not being cleared in the same cycle. A repeat of a hardware-corrected type leaves it unchanged. Writing 1 to bit 8 clears it.
- R4: Accepted events of different types set their own bits side by side and do not set `status[8]`.
- R5: An event whose `ev_txn` equals that of the last accepted event and whose `ev_sub` is greater than or equal to that event's subunit is ignored. It changes no status bit, no flag and no captured field. A lower subunit, or a different tag, starts a new transaction and is accepted.
- R6: `status[9]` takes the `ev_priv` value of each accepted event. Writing 1 to bit 9 clears it.
- R7: Classes by default are types 0 to 2 uncorrectable, types 3 and 4 software-correctable, and types 5 to 7 hardware-corrected. `fault_addr` loads `ev_addr` from an accepted event when the field is unlocked. While the field is locked it is overwritten only by an event of a strictly more severe class than its owner.
- R8: A captured field unlocks in the cycle in which its owner's status bit is cleared, whatever other bits stay set. Its value is kept until the next capture, and an event in that same cycle may capture at once.
- R9: `dsyn_out` and `tsyn_out` follow the rules of R7 and R8. The data syndrome loads from every type by default. The tag syndrome loads only from types 0, 5, 6 and 7 by default.
- R10: `trap_req` is high in the same cycle in which `irq_en` is high and any of status bits 0 to 4 (the default trap mask) is set.
- R11: When a clear and a new accepted event hit the same status bit in one cycle, the bit stays set, the repeat flag is not set by that event, and a capture owned by that bit stays locked.
- R12: During and after reset, `status`, `fault_addr`, `dsyn_out`, `tsyn_out` and `trap_req` are zero, and every captured field is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An error event is present this cycle |
| ev_type | input | 3 | Error type index |
| ev_addr | input | 32 | Address of the faulting access |
| ev_dsyn | input | 9 | Data ECC syndrome |
| ev_tsyn | input | 4 | Tag ECC syndrome |
| ev_priv | input | 1 | Privilege level at detection |
| ev_txn | input | 4 | Transaction tag |
| ev_sub | input | 2 | 16-byte subunit index within the transaction |
| clr_en | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 10 | Bits to clear: [7:0] types, [8] repeat flag, [9] privilege |
| irq_en | input | 1 | Interrupt enable gating the trap request |
| status | output | 10 | {privilege, repeat flag, type bits[7:0]} |
| fault_addr | output | 32 | Captured fault address |
| dsyn_out | output | 9 | Captured data syndrome |
| tsyn_out | output | 4 | Captured tag syndrome |
| trap_req | output | 1 | Trap request |

## Verification
The assertions assume that `ev_type` is always below the number of types and that at most one event arrives per cycle, which the port shape already enforces. The transaction filter also assumes that subunit indices rise within a transfer and that a lower index means a new transfer. The stimulus draws every type from the valid range and draws tags from a small set, so that same-tag bursts, rising and falling subunits and tag reuse all occur often. It makes clear writes sparse and random, so that clears of a capture owner, clears of other bits and same-cycle clear-and-set cases appear among the events.

// File: rtl/esc_pkg.sv
package esc_pkg;

   // Severity classes; a numerically larger code is more severe.
   typedef enum logic [1:0] {
      CLS_HW  = 2'd0,
      CLS_SW  = 2'd1,
      CLS_UE  = 2'd2,
      CLS_BAD = 2'd3
   } err_class_e;

   // True when class a may displace a capture held by class b.
   function automatic logic outranks(input err_class_e a, input err_class_e b);
      return int'(a) > int'(b);
   endfunction

   // Only uncorrectable and software-correctable repeats raise the repeat flag.
   function automatic logic counts_as_repeat(input err_class_e c);
      return c != CLS_HW;
   endfunction

endpackage

// File: rtl/esc_txn_filter.sv
module esc_txn_filter #(
   parameter int TXN_W = 4,
   parameter int SUB_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [TXN_W-1:0] ev_txn,
   input  logic [SUB_W-1:0] ev_sub,
   output logic             ev_take
);

   logic             armed_q;
   logic [TXN_W-1:0] held_txn_q;
   logic [SUB_W-1:0] held_sub_q;
   logic             same_burst;

   always_comb begin
      same_burst = armed_q && (ev_txn == held_txn_q) && (ev_sub >= held_sub_q);
      ev_take    = ev_valid && !same_burst;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q    <= 1'b0;
         held_txn_q <= '0;
         held_sub_q <= '0;
      end else if (ev_take) begin
         armed_q    <= 1'b1;
         held_txn_q <= ev_txn;
         held_sub_q <= ev_sub;
      end
   end

   // R5: with nothing logged yet, any event is accepted
   p_first_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !armed_q) |-> ev_take);

   // R5: an accepted event becomes the reference for later subunits
   p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_take |=> (armed_q && held_txn_q == $past(ev_txn) && held_sub_q == $past(ev_sub)));

endmodule

// File: rtl/esc_status.sv
module esc_status
   import esc_pkg::*;
#(
   parameter int                    NUM_ERR   = 8,
   parameter int                    TYPE_W    = 3,
   parameter logic [2*NUM_ERR-1:0]  CLASS_MAP = '0,
   parameter logic [NUM_ERR-1:0]    TRAP_MASK = '1,
   parameter bit                    TRAP_REG  = 1'b0,
   localparam int                   STAT_W    = NUM_ERR + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_take,
   input  logic [TYPE_W-1:0] ev_type,
   input  logic              ev_priv,
   input  logic              clr_en,
   input  logic [STAT_W-1:0] clr_data,
   input  logic              irq_en,
   output logic [STAT_W-1:0] status,
   output logic [NUM_ERR-1:0] fall,
   output logic              trap_req
);

   localparam int ME_BIT   = NUM_ERR;
   localparam int PRIV_BIT = NUM_ERR + 1;

   logic [NUM_ERR-1:0] err_q, err_d, set_vec, clr_vec;
   logic               me_q, me_d, priv_q, priv_d, repeat_hit;
   err_class_e         ev_cls;

   always_comb begin
      ev_cls  = err_class_e'(CLASS_MAP[2*ev_type +: 2]);
      set_vec = '0;
      if (ev_take) set_vec[ev_type] = 1'b1;
      clr_vec    = clr_en ? clr_data[NUM_ERR-1:0] : '0;
      // a new event overrides a clear of the same bit
      err_d      = (err_q & ~clr_vec) | set_vec;
      repeat_hit = ev_take && err_q[ev_type] && !clr_vec[ev_type] && counts_as_repeat(ev_cls);
      me_d       = repeat_hit | (me_q & ~(clr_en & clr_data[ME_BIT]));
      priv_d     = ev_take ? ev_priv : (priv_q & ~(clr_en & clr_data[PRIV_BIT]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= '0;
         me_q   <= 1'b0;
         priv_q <= 1'b0;
      end else begin
         err_q  <= err_d;
         me_q   <= me_d;
         priv_q <= priv_d;
      end
   end

   assign fall   = err_q & ~err_d;
   assign status = {priv_q, me_q, err_q};

   generate
      if (TRAP_REG) begin : g_trap_reg
         logic trap_q;
         always_ff @(posedge clk) begin
            if (!rst_n) trap_q <= 1'b0;
            else        trap_q <= irq_en && |(err_d & TRAP_MASK);
         end
         assign trap_req = trap_q;

         // R10: a disabled interrupt suppresses the next request
         p_trap_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |=> !trap_req);
      end else begin : g_trap_comb
         assign trap_req = irq_en && |(err_q & TRAP_MASK);

         // R10: no request while interrupts are disabled
         p_trap_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |-> !trap_req);
      end
   endgenerate

   // R2: without a clear no bit drops
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en |=> ((err_q & $past(err_q)) == $past(err_q)));

   // R1: cleared bits read zero when no event competes
   p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !ev_take) |=> ((err_q & $past(clr_data[NUM_ERR-1:0])) == '0));

   // R3: severe repeat raises the flag
   p_me_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_take && err_q[ev_type] && !(clr_en && clr_data[ev_type]) && ev_cls != CLS_HW) |=> me_q);

   // R3: a corrected repeat never raises the flag
   p_me_hw_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_take && ev_cls == CLS_HW && !me_q) |=> !me_q);

   // R11: the event wins over a clear of its own bit
   p_new_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_take |=> err_q[$past(ev_type)]);

endmodule

// File: rtl/esc_capture.sv
module esc_capture
   import esc_pkg::*;
#(
   parameter int                    W         = 8,
   parameter int                    NUM_ERR   = 8,
   parameter int                    TYPE_W    = 3,
   parameter logic [2*NUM_ERR-1:0]  CLASS_MAP = '0,
   parameter logic [NUM_ERR-1:0]    LOAD_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_take,
   input  logic [TYPE_W-1:0]  ev_type,
   input  logic [W-1:0]       ev_data,
   input  logic [NUM_ERR-1:0] fall,
   output logic [W-1:0]       value
);

   logic [W-1:0]      val_q;
   logic              lock_q, lock_eff, wants, outranked, take;
   logic [TYPE_W-1:0] own_q;
   err_class_e        ev_cls, own_cls;

   always_comb begin
      ev_cls    = err_class_e'(CLASS_MAP[2*ev_type +: 2]);
      own_cls   = err_class_e'(CLASS_MAP[2*own_q +: 2]);
      lock_eff  = lock_q && !fall[own_q];
      wants     = ev_take && LOAD_MASK[ev_type];
      outranked = outranks(ev_cls, own_cls);
      take      = wants && (!lock_eff || outranked);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q  <= '0;
         lock_q <= 1'b0;
         own_q  <= '0;
      end else begin
         lock_q <= take | lock_eff;
         if (take) begin
            val_q <= ev_data;
            own_q <= ev_type;
         end
      end
   end

   assign value = val_q;

   // R7: an unlocked field takes the first eligible event
   p_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && wants) |=> (lock_q && val_q == $past(ev_data)));

   // R7: a locked field ignores events that do not outrank its owner
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !fall[own_q] && !(wants && outranked)) |=> (lock_q && $stable(val_q)));

   // R8: clearing the owner unlocks and keeps the value
   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && fall[own_q] && !wants) |=> (!lock_q && $stable(val_q)));

endmodule

// File: rtl/err_status_capture.sv
module err_status_capture
   import esc_pkg::*;
#(
   parameter int                   NUM_ERR   = 8,
   parameter int                   ADDR_W    = 32,
   parameter int                   DSYN_W    = 9,
   parameter int                   TSYN_W    = 4,
   parameter int                   TXN_W     = 4,
   parameter int                   SUB_W     = 2,
   parameter logic [2*NUM_ERR-1:0] CLASS_MAP = 16'h016A,
   parameter logic [NUM_ERR-1:0]   TRAP_MASK = 8'h1F,
   parameter logic [NUM_ERR-1:0]   DSYN_MASK = 8'hFF,
   parameter logic [NUM_ERR-1:0]   TSYN_MASK = 8'hE1,
   parameter bit                   TRAP_REG  = 1'b0,
   localparam int                  TYPE_W    = $clog2(NUM_ERR),
   localparam int                  STAT_W    = NUM_ERR + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [TYPE_W-1:0] ev_type,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DSYN_W-1:0] ev_dsyn,
   input  logic [TSYN_W-1:0] ev_tsyn,
   input  logic              ev_priv,
   input  logic [TXN_W-1:0]  ev_txn,
   input  logic [SUB_W-1:0]  ev_sub,
   input  logic              clr_en,
   input  logic [STAT_W-1:0] clr_data,
   input  logic              irq_en,
   output logic [STAT_W-1:0] status,
   output logic [ADDR_W-1:0] fault_addr,
   output logic [DSYN_W-1:0] dsyn_out,
   output logic [TSYN_W-1:0] tsyn_out,
   output logic              trap_req
);

   // elaboration-time parameter checks
   generate
      if (NUM_ERR < 2) begin : g_bad_num
         $error("NUM_ERR must be at least 2");
      end
      if (ADDR_W < 1 || DSYN_W < 1 || TSYN_W < 1 || TXN_W < 1 || SUB_W < 1) begin : g_bad_width
         $error("all field widths must be positive");
      end
      for (genvar i = 0; i < NUM_ERR; i++) begin : g_cls_chk
         if (CLASS_MAP[2*i +: 2] == 2'd3) begin : g_bad_cls
            $error("class code 3 is reserved");
         end
      end
   endgenerate

   logic               ev_take;
   logic [NUM_ERR-1:0] fall;

   esc_txn_filter #(.TXN_W(TXN_W), .SUB_W(SUB_W)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ev_valid),
      .ev_txn   (ev_txn),
      .ev_sub   (ev_sub),
      .ev_take  (ev_take)
   );

   esc_status #(
      .NUM_ERR   (NUM_ERR),
      .TYPE_W    (TYPE_W),
      .CLASS_MAP (CLASS_MAP),
      .TRAP_MASK (TRAP_MASK),
      .TRAP_REG  (TRAP_REG)
   ) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_take  (ev_take),
      .ev_type  (ev_type),
      .ev_priv  (ev_priv),
      .clr_en   (clr_en),
      .clr_data (clr_data),
      .irq_en   (irq_en),
      .status   (status),
      .fall     (fall),
      .trap_req (trap_req)
   );

   esc_capture #(
      .W(ADDR_W), .NUM_ERR(NUM_ERR), .TYPE_W(TYPE_W),
      .CLASS_MAP(CLASS_MAP), .LOAD_MASK({NUM_ERR{1'b1}})
   ) u_cap_addr (
      .clk(clk), .rst_n(rst_n), .ev_take(ev_take), .ev_type(ev_type),
      .ev_data(ev_addr), .fall(fall), .value(fault_addr)
   );

   esc_capture #(
      .W(DSYN_W), .NUM_ERR(NUM_ERR), .TYPE_W(TYPE_W),
      .CLASS_MAP(CLASS_MAP), .LOAD_MASK(DSYN_MASK)
   ) u_cap_dsyn (
      .clk(clk), .rst_n(rst_n), .ev_take(ev_take), .ev_type(ev_type),
      .ev_data(ev_dsyn), .fall(fall), .value(dsyn_out)
   );

   esc_capture #(
      .W(TSYN_W), .NUM_ERR(NUM_ERR), .TYPE_W(TYPE_W),
      .CLASS_MAP(CLASS_MAP), .LOAD_MASK(TSYN_MASK)
   ) u_cap_tsyn (
      .clk(clk), .rst_n(rst_n), .ev_take(ev_take), .ev_type(ev_type),
      .ev_data(ev_tsyn), .fall(fall), .value(tsyn_out)
   );

   // R5: a filtered event leaves the status word untouched
   p_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_take && !clr_en) |=> $stable(status));

   // R1: an idle cycle changes nothing visible to software
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid && !clr_en) |=> ($stable(status) && $stable(fault_addr)));

endmodule

// File: tb/err_status_capture_tb.sv
module err_status_capture_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] CLASS_MAP = 16'h016A;
   localparam logic [7:0]  TRAP_MASK = 8'h1F;
   localparam logic [7:0]  LMASK [3] = '{8'hFF, 8'hFF, 8'hE1};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ev_valid, ev_priv, clr_en, irq_en;
   logic [2:0]  ev_type;
   logic [31:0] ev_addr;
   logic [8:0]  ev_dsyn;
   logic [3:0]  ev_tsyn, ev_txn;
   logic [1:0]  ev_sub;
   logic [9:0]  clr_data, status;
   logic [31:0] fault_addr;
   logic [8:0]  dsyn_out;
   logic [3:0]  tsyn_out;
   logic        trap_req;

   int n_chk = 0;
   int n_err = 0;

   // reference state built from the requirements
   logic [7:0]  m_stat;
   bit          m_me, m_priv, m_armed;
   logic [3:0]  m_txn;
   logic [1:0]  m_sub;
   logic [31:0] m_val [3];
   bit          m_lk [3];
   int          m_own [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   err_status_capture u_dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type),
      .ev_addr(ev_addr), .ev_dsyn(ev_dsyn), .ev_tsyn(ev_tsyn), .ev_priv(ev_priv),
      .ev_txn(ev_txn), .ev_sub(ev_sub), .clr_en(clr_en), .clr_data(clr_data),
      .irq_en(irq_en), .status(status), .fault_addr(fault_addr),
      .dsyn_out(dsyn_out), .tsyn_out(tsyn_out), .trap_req(trap_req)
   );

   function automatic int cls(input int t);
      return int'((CLASS_MAP >> (2*t)) & 16'h3);
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_stat = '0; m_me = 0; m_priv = 0; m_armed = 0; m_txn = '0; m_sub = '0;
      for (int f = 0; f < 3; f++) begin
         m_val[f] = '0; m_lk[f] = 0; m_own[f] = 0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ev_valid = 0; ev_type = '0; ev_addr = '0; ev_dsyn = '0;
      ev_tsyn = '0; ev_priv = 0; ev_txn = '0; ev_sub = '0; clr_en = 0;
      clr_data = '0; irq_en = 1'b1;
      model_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R12", "status", {22'b0, status}, 32'h0);
      chk("R12", "fault_addr", fault_addr, 32'h0);
      chk("R12", "dsyn", {23'b0, dsyn_out}, 32'h0);
      chk("R12", "tsyn", {28'b0, tsyn_out}, 32'h0);
      chk("R12", "trap", {31'b0, trap_req}, 32'h0);
      rst_n = 1'b1;
   endtask

   // one clock: drive at negedge, advance the model, compare at next negedge
   task automatic cyc(input string tag, input bit v, input int t, input logic [31:0] a,
                      input logic [8:0] ds, input logic [3:0] ts, input bit p,
                      input logic [3:0] tx, input logic [1:0] sb, input bit ce,
                      input logic [9:0] cd, input bit ie);
      bit acc, lke;
      logic [9:0]  clr;
      logic [7:0]  old, nst, fl;
      logic [31:0] data;
      ev_valid = v; ev_type = 3'(t); ev_addr = a; ev_dsyn = ds; ev_tsyn = ts;
      ev_priv = p; ev_txn = tx; ev_sub = sb; clr_en = ce; clr_data = cd; irq_en = ie;
      acc = v && !(m_armed && tx == m_txn && sb >= m_sub);
      clr = ce ? cd : 10'h0;
      old = m_stat;
      nst = old & ~clr[7:0];
      if (acc) nst[t] = 1'b1;
      if (acc && old[t] && !clr[t] && cls(t) != 0) m_me = 1;
      else m_me = m_me & ~clr[8];
      if (acc) m_priv = p;
      else m_priv = m_priv & ~clr[9];
      fl = old & ~nst;
      for (int f = 0; f < 3; f++) begin
         data = (f == 0) ? a : (f == 1) ? {23'b0, ds} : {28'b0, ts};
         lke = m_lk[f] && !fl[m_own[f]];
         if (acc && LMASK[f][t] && (!lke || cls(t) > cls(m_own[f]))) begin
            m_val[f] = data; m_own[f] = t; m_lk[f] = 1;
         end else begin
            m_lk[f] = lke;
         end
      end
      m_stat = nst;
      if (acc) begin
         m_armed = 1; m_txn = tx; m_sub = sb;
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "status", {22'b0, status}, {22'b0, m_priv, m_me, m_stat});
      chk(tag, "fault_addr", fault_addr, m_val[0]);
      chk(tag, "dsyn", {23'b0, dsyn_out}, m_val[1]);
      chk(tag, "tsyn", {28'b0, tsyn_out}, m_val[2]);
      chk(tag, "trap", {31'b0, trap_req}, {31'b0, ie && |(m_stat & TRAP_MASK)});
   endtask

   task automatic idle(input string tag, input bit ce, input logic [9:0] cd, input bit ie);
      cyc(tag, 0, 0, 32'h0, 9'h0, 4'h0, 0, 4'h0, 2'h0, ce, cd, ie);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'd7351);
      do_reset();

      // R2, R9: first event captures; type 3 does not load the tag syndrome
      cyc("R2", 1, 3, 32'h1000_0030, 9'h033, 4'h3, 0, 4'd1, 2'd0, 0, 10'h0, 0);
      chk("R2", "bit3", {31'b0, status[3]}, 32'h1);
      chk("R9", "tsyn_skip", {28'b0, tsyn_out}, 32'h0);
      // R4: second type sets its own bit, no repeat flag; R7 address held
      cyc("R4", 1, 6, 32'h1000_0060, 9'h066, 4'h6, 0, 4'd2, 2'd0, 0, 10'h0, 0);
      chk("R4", "status", {22'b0, status}, 32'h048);
      chk("R7", "addr_held", fault_addr, 32'h1000_0030);
      // R3: software-correctable repeat sets the flag
      cyc("R3", 1, 3, 32'h1000_0031, 9'h034, 4'h3, 0, 4'd3, 2'd0, 0, 10'h0, 0);
      chk("R3", "me", {31'b0, status[8]}, 32'h1);
      idle("R3", 1, 10'h100, 0);
      // R3: corrected repeat does not
      cyc("R3", 1, 6, 32'h1000_0061, 9'h067, 4'h6, 0, 4'd4, 2'd0, 0, 10'h0, 0);
      chk("R3", "me_hw", {31'b0, status[8]}, 32'h0);
      // R7: uncorrectable outranks
      cyc("R7", 1, 0, 32'h1000_0000, 9'h100, 4'hA, 0, 4'd5, 2'd0, 0, 10'h0, 0);
      chk("R7", "addr_over", fault_addr, 32'h1000_0000);
      // R8: clear owner, value kept; next event captures while bits 3,6 stay set
      idle("R8", 1, 10'h001, 0);
      chk("R8", "addr_kept", fault_addr, 32'h1000_0000);
      cyc("R8", 1, 6, 32'h1000_0070, 9'h077, 4'h7, 0, 4'd6, 2'd0, 0, 10'h0, 0);
      chk("R8", "addr_new", fault_addr, 32'h1000_0070);
      // R5: later subunit of the same transaction ignored
      cyc("R5", 1, 1, 32'h2000_0000, 9'h011, 4'h1, 0, 4'd6, 2'd1, 0, 10'h0, 0);
      chk("R5", "drop", {22'b0, status}, 32'h048);
      cyc("R5", 1, 2, 32'h2000_0020, 9'h022, 4'h2, 0, 4'd7, 2'd2, 0, 10'h0, 0);
      cyc("R5", 1, 1, 32'h2000_0010, 9'h012, 4'h1, 0, 4'd7, 2'd3, 0, 10'h0, 0);
      chk("R5", "drop2", {22'b0, status}, 32'h04C);
      cyc("R5", 1, 1, 32'h2000_0011, 9'h013, 4'h1, 0, 4'd7, 2'd1, 0, 10'h0, 0);
      chk("R5", "new_txn", {22'b0, status}, 32'h04E);
      // R11: clear and event on the same bit
      cyc("R11", 1, 3, 32'h3000_0000, 9'h035, 4'h3, 0, 4'd8, 2'd0, 1, 10'h008, 0);
      chk("R11", "bit3", {31'b0, status[3]}, 32'h1);
      chk("R11", "me", {31'b0, status[8]}, 32'h0);
      // R6: privilege capture and clear
      cyc("R6", 1, 5, 32'h3000_0050, 9'h055, 4'h5, 1, 4'd9, 2'd0, 0, 10'h0, 0);
      chk("R6", "status", {22'b0, status}, 32'h26E);
      idle("R6", 1, 10'h200, 0);
      chk("R6", "priv_clr", {31'b0, status[9]}, 32'h0);
      // R10: gating and trap mask
      idle("R10", 0, 10'h0, 0);
      chk("R10", "gated", {31'b0, trap_req}, 32'h0);
      idle("R10", 0, 10'h0, 1);
      chk("R10", "raised", {31'b0, trap_req}, 32'h1);
      idle("R10", 1, 10'h01F, 1);
      chk("R10", "hw_only", {31'b0, trap_req}, 32'h0);
      // R1: zero write and idle change nothing
      idle("R1", 1, 10'h000, 1);
      chk("R1", "zero_wr", {22'b0, status}, 32'h060);
      idle("R1", 0, 10'h000, 1);
      chk("R1", "idle", {22'b0, status}, 32'h060);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         bit v, ce;
         v  = ($urandom % 10) < 7;
         ce = ($urandom % 7) == 0;
         cyc("R2", v, int'($urandom % 8), $urandom, 9'($urandom), 4'($urandom),
             1'($urandom), 4'($urandom % 4), 2'($urandom), ce,
             10'($urandom & $urandom & $urandom), ($urandom % 4) != 0);
      end

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule